// File: doc/BRIEF.md
# Two-Player Noughts-and-Crosses Match Controller

This block runs a match of noughts and crosses between two players on a 3x3 board. Each player steers a selection cursor with single-cycle up, down, left and right pulses, which come already debounced. A place pulse puts the current player's mark into the cell under the cursor. The block checks that the move is legal, stores the mark and hands the turn to the other player. It then looks at every row, column and diagonal for a winner and also detects a full board with no winner.

The outputs are the packed board contents, the cursor row and column, the player to move and the match result, all meant for an external display. A synchronous new-game input, or the asynchronous reset, clears the board and returns the cursor to the top-left cell. Either one also gives the first move to player 1.

Top module: `ttt_match`

## Requirements
- R1: After reset or a new-game pulse, every cell is empty (00), the cursor is at row 0, column 0, player 1 is to move (`turn_o`=0) and the result is in-play (00).
- R2: Each cell is 2 bits in `board_o`, with cell index = row*3+col at bits [2*idx+1:2*idx]. The encoding is 00 empty, 01 X (player 1), 10 O (player 2).
- R3: An up pulse decrements the row and a down pulse increments it. A left pulse decrements the column and a right pulse increments it. Each takes effect on the next clock edge.
- R4: The cursor saturates at rows and columns 0 and 2 and does not wrap around.
- R5: A place pulse on an empty cell while the match is in play writes the current player's mark there on the next edge and toggles `turn_o`.
- R6: A place pulse on an occupied cell changes neither the board nor the turn.
- R7: Three equal non-empty marks in any row, column or diagonal set the result to 01 (player 1 wins) or 10 (player 2 wins) in the cycle after the winning mark appears.
- R8: A full board with no winning line sets the result to 11 (draw).
- R9: Once the result is not 00, place and direction pulses change neither the board, the cursor nor the turn until a new game starts.
- R10: If more than one direction pulse is high in a cycle, only one is applied, in the priority up, down, left, right. A place pulse in the same cycle uses the cursor position from before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| new_game_i | input | 1 | Synchronous clear of the match |
| up_i | input | 1 | Cursor up pulse |
| down_i | input | 1 | Cursor down pulse |
| left_i | input | 1 | Cursor left pulse |
| right_i | input | 1 | Cursor right pulse |
| place_i | input | 1 | Place mark pulse |
| board_o | output | 18 | Packed board, 2 bits per cell |
| cur_row_o | output | 2 | Cursor row |
| cur_col_o | output | 2 | Cursor column |
| turn_o | output | 1 | 0 = player 1 (X), 1 = player 2 (O) to move |
| result_o | output | 2 | 00 play, 01 X wins, 10 O wins, 11 draw |

## Verification
The hardest situation to reach from the ports is a full board with no winning line, because random play almost always ends in a win first. The bench therefore plays a directed nine-move draw sequence, steering the cursor with direction pulses to each cell. It also drives long random bursts of moves and placements, and each one is compared against a bench-side board model. Those bursts produce wins on different lines, lock-out after the result is set, and moves rejected on occupied cells.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
  localparam int unsigned SIDE   = 3;
  localparam int unsigned NCELL  = SIDE * SIDE;
  localparam int unsigned CW     = 2;
  localparam int unsigned POSW   = 2;

  typedef enum logic [1:0] {
    CELL_EMPTY = 2'b00,
    CELL_X     = 2'b01,
    CELL_O     = 2'b10
  } cell_e;

  typedef enum logic [1:0] {
    RES_PLAY = 2'b00,
    RES_XWIN = 2'b01,
    RES_OWIN = 2'b10,
    RES_DRAW = 2'b11
  } result_e;

  function automatic logic [POSW-1:0] step_pos(logic [POSW-1:0] pos, logic dec, logic inc);
    logic [POSW-1:0] r;
    r = pos;
    if (dec && pos != '0) r = pos - 1'b1;
    else if (inc && pos != POSW'(SIDE - 1)) r = pos + 1'b1;
    return r;
  endfunction

  function automatic int unsigned cell_index(logic [POSW-1:0] row, logic [POSW-1:0] col);
    return int'(row) * SIDE + int'(col);
  endfunction
endpackage

// File: rtl/ttt_cursor.sv
module ttt_cursor
  import ttt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            hold_i,
  input  logic            up_i,
  input  logic            down_i,
  input  logic            left_i,
  input  logic            right_i,
  output logic [POSW-1:0] row_o,
  output logic [POSW-1:0] col_o
);
  logic [POSW-1:0] row_q, col_q, row_d, col_d;
  logic vert_sel;

  assign vert_sel = up_i | down_i;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (vert_sel) row_d = step_pos(row_q, up_i, down_i & ~up_i);
    else          col_d = step_pos(col_q, left_i, right_i & ~left_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (clear_i) begin
      row_q <= '0;
      col_q <= '0;
    end else if (!hold_i) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;

  a_r4_row_bound: assert property (@(posedge clk_i) disable iff (!rst_ni) row_q <= POSW'(SIDE - 1));
  a_r4_col_bound: assert property (@(posedge clk_i) disable iff (!rst_ni) col_q <= POSW'(SIDE - 1));
  a_r9_hold_cursor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clear_i) |=> ($stable(row_q) && $stable(col_q)));
  a_r3_one_axis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($changed(row_q) && $changed(col_q) && !$past(clear_i)));
endmodule

// File: rtl/ttt_judge.sv
module ttt_judge
  import ttt_pkg::*;
(
  input  logic [NCELL*CW-1:0] board_i,
  output logic [1:0]          result_o
);
  localparam int unsigned NLINE = 2 * SIDE + 2;

  logic [NLINE-1:0] x_line, o_line;
  logic             full;

  function automatic logic [CW-1:0] cell_at(logic [NCELL*CW-1:0] b, int unsigned r, int unsigned c);
    return b[(r*SIDE+c)*CW +: CW];
  endfunction

  function automatic logic line_owned(logic [NCELL*CW-1:0] b, logic [CW-1:0] mark,
                                      int unsigned r0, int unsigned c0, int dr, int dc);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < SIDE; k++)
      if (cell_at(b, int'(r0) + k*dr, int'(c0) + k*dc) != mark) ok = 1'b0;
    return ok;
  endfunction

  for (genvar g = 0; g < SIDE; g++) begin : g_rc
    assign x_line[g]        = line_owned(board_i, CELL_X, g, 0, 0, 1);
    assign o_line[g]        = line_owned(board_i, CELL_O, g, 0, 0, 1);
    assign x_line[SIDE + g] = line_owned(board_i, CELL_X, 0, g, 1, 0);
    assign o_line[SIDE + g] = line_owned(board_i, CELL_O, 0, g, 1, 0);
  end
  assign x_line[2*SIDE]   = line_owned(board_i, CELL_X, 0, 0, 1, 1);
  assign o_line[2*SIDE]   = line_owned(board_i, CELL_O, 0, 0, 1, 1);
  assign x_line[2*SIDE+1] = line_owned(board_i, CELL_X, 0, SIDE-1, 1, -1);
  assign o_line[2*SIDE+1] = line_owned(board_i, CELL_O, 0, SIDE-1, 1, -1);

  always_comb begin
    full = 1'b1;
    for (int i = 0; i < NCELL; i++)
      if (board_i[i*CW +: CW] == CELL_EMPTY) full = 1'b0;
  end

  always_comb begin
    if (|x_line)      result_o = RES_XWIN;
    else if (|o_line) result_o = RES_OWIN;
    else if (full)    result_o = RES_DRAW;
    else              result_o = RES_PLAY;
  end
endmodule

// File: rtl/ttt_match.sv
module ttt_match
  import ttt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                new_game_i,
  input  logic                up_i,
  input  logic                down_i,
  input  logic                left_i,
  input  logic                right_i,
  input  logic                place_i,
  output logic [NCELL*CW-1:0] board_o,
  output logic [POSW-1:0]     cur_row_o,
  output logic [POSW-1:0]     cur_col_o,
  output logic                turn_o,
  output logic [1:0]          result_o
);
  logic [NCELL*CW-1:0] board_q;
  logic                turn_q;
  logic [1:0]          result_q, judged;
  logic [POSW-1:0]     row, col;
  logic                game_over, place_ok, cell_free;
  logic [CW-1:0]       sel_cell;

  assign game_over = (result_q != RES_PLAY);

  ttt_cursor u_cursor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (new_game_i),
    .hold_i  (game_over),
    .up_i    (up_i),
    .down_i  (down_i),
    .left_i  (left_i),
    .right_i (right_i),
    .row_o   (row),
    .col_o   (col)
  );

  assign sel_cell  = board_q[cell_index(row, col)*CW +: CW];
  assign cell_free = (sel_cell == CELL_EMPTY);
  assign place_ok  = place_i && cell_free && !game_over && !new_game_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      board_q <= '0;
      turn_q  <= 1'b0;
    end else if (new_game_i) begin
      board_q <= '0;
      turn_q  <= 1'b0;
    end else if (place_ok) begin
      board_q[cell_index(row, col)*CW +: CW] <= turn_q ? CELL_O : CELL_X;
      turn_q <= ~turn_q;
    end
  end

  ttt_judge u_judge (
    .board_i  (board_q),
    .result_o (judged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         result_q <= RES_PLAY;
    else if (new_game_i) result_q <= RES_PLAY;
    else if (!game_over) result_q <= judged;
  end

  assign board_o   = board_q;
  assign cur_row_o = row;
  assign cur_col_o = col;
  assign turn_o    = turn_q;
  assign result_o  = result_q;

  a_r5_turn_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    place_ok |=> (turn_q != $past(turn_q)));
  a_r6_occupied_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (place_i && !cell_free && !new_game_i) |=> ($stable(board_q) && $stable(turn_q)));
  a_r9_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (game_over && !new_game_i) |=> ($stable(board_q) && $stable(result_q)));
  a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_game_i |=> (board_q == '0 && !turn_q && result_q == RES_PLAY));
  a_r2_one_cell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!new_game_i) |=> ($countones(board_q ^ $past(board_q)) <= 1));
endmodule

// File: tb/ttt_match_bench.sv
module ttt_match_bench;
  logic clk = 0, rst_n = 0;
  logic ng = 0, up = 0, dn = 0, lf = 0, rt = 0, pl = 0;
  logic [17:0] board;
  logic [1:0] row, col, res;
  logic turn;
  int checks = 0, errors = 0;
  logic watchdog_hit = 0;

  logic [1:0] m_cell [9];
  int m_row, m_col, m_turn, m_res;

  always #2.5 clk = ~clk;

  ttt_match u_ttt_match (
    .clk_i(clk), .rst_ni(rst_n), .new_game_i(ng), .up_i(up), .down_i(dn),
    .left_i(lf), .right_i(rt), .place_i(pl), .board_o(board),
    .cur_row_o(row), .cur_col_o(col), .turn_o(turn), .result_o(res)
  );

  function automatic int judge_model();
    int w;
    int l[8][3] = '{'{0,1,2},'{3,4,5},'{6,7,8},'{0,3,6},'{1,4,7},'{2,5,8},'{0,4,8},'{2,4,6}};
    bit full = 1;
    w = 0;
    for (int i = 0; i < 8; i++)
      if (m_cell[l[i][0]] != 0 && m_cell[l[i][0]] == m_cell[l[i][1]] && m_cell[l[i][1]] == m_cell[l[i][2]])
        if (w == 0 || m_cell[l[i][0]] == 1) w = m_cell[l[i][0]];
    for (int i = 0; i < 9; i++) if (m_cell[i] == 0) full = 0;
    if (w != 0) return w;
    return full ? 3 : 0;
  endfunction

  function automatic logic [17:0] pack_model();
    logic [17:0] b;
    for (int i = 0; i < 9; i++) b[2*i +: 2] = m_cell[i];
    return b;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 9; i++) m_cell[i] = 0;
    m_row = 0; m_col = 0; m_turn = 0; m_res = 0;
  endtask

  // applies one cycle of stimulus to the model: same edge as the DUT
  task automatic model_step(bit u, bit d, bit l, bit r, bit p, bit n);
    int idx;
    if (n) begin model_clear(); return; end
    if (m_res != 0) return;
    idx = m_row*3 + m_col;
    if (p && m_cell[idx] == 0) begin
      m_cell[idx] = (m_turn == 0) ? 2'b01 : 2'b10;
      m_turn ^= 1;
    end
    if (u) begin if (m_row > 0) m_row--; end
    else if (d) begin if (m_row < 2) m_row++; end
    else if (l) begin if (m_col > 0) m_col--; end
    else if (r) begin if (m_col < 2) m_col++; end
  endtask

  // result register samples the board one edge later
  int pend_res;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit u, bit d, bit l, bit r, bit p, bit n);
    up = u; dn = d; lf = l; rt = r; pl = p; ng = n;
    @(posedge clk);
    model_step(u, d, l, r, p, n);
    #1;
    up = 0; dn = 0; lf = 0; rt = 0; pl = 0; ng = 0;
    // one settle cycle so result catches up
    @(posedge clk);
    if (m_res == 0) m_res = judge_model();
    #1;
  endtask

  task automatic check_all(string tag);
    check({tag, " R2 board"}, 32'(board), 32'(pack_model()));
    check({tag, " R3 row"}, 32'(row), 32'(m_row));
    check({tag, " R3 col"}, 32'(col), 32'(m_col));
    check({tag, " R5 turn"}, 32'(turn), 32'(m_turn));
    check({tag, " R7 result"}, 32'(res), 32'(m_res));
  endtask

  task automatic goto(int r, int c);
    while (m_row > r) cyc(1,0,0,0,0,0);
    while (m_row < r) cyc(0,1,0,0,0,0);
    while (m_col > c) cyc(0,0,1,0,0,0);
    while (m_col < c) cyc(0,0,0,1,0,0);
  endtask

  task automatic put(int r, int c);
    goto(r, c);
    cyc(0,0,0,0,1,0);
  endtask

  initial begin
    #200000;
    watchdog_hit = 1;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    check("R1 reset board", 32'(board), 0);
    check("R1 reset result", 32'(res), 0);
    check("R1 reset turn", 32'(turn), 0);
    check("R1 reset cursor", 32'({row, col}), 0);

    // R4 edge saturation
    cyc(1,0,0,0,0,0); cyc(0,0,1,0,0,0);
    check_all("R4 top-left clamp");
    repeat (4) cyc(0,1,0,0,0,0);
    repeat (4) cyc(0,0,0,1,0,0);
    check_all("R4 bottom-right clamp");
    // R10 priority: up+right -> up only
    cyc(1,0,0,1,0,0);
    check_all("R10 up over right");
    cyc(0,0,1,1,0,0);
    check_all("R10 left over right");
    // R10 place with move uses old cursor
    cyc(0,0,1,0,1,0);
    check_all("R10 place then move");
    // R6 occupied
    cyc(0,0,0,1,0,0);
    cyc(0,0,0,0,1,0);
    check_all("R6 occupied ignored");
    check("R6 turn kept", 32'(turn), 32'(1));

    // R7 X wins row 0
    cyc(0,0,0,0,0,1);
    put(0,0); put(1,0); put(0,1); put(1,1); put(0,2);
    check_all("R7 X row win");
    check("R7 X wins code", 32'(res), 32'(2'b01));
    // R9 lockout
    cyc(0,1,0,0,1,0); cyc(0,0,1,0,0,0);
    check_all("R9 locked after win");
    // R1 new game
    cyc(0,0,0,0,0,1);
    check_all("R1 new game");

    // O wins diagonal
    put(0,1); put(0,0); put(0,2); put(1,1); put(1,0); put(2,2);
    check("R7 O wins code", 32'(res), 32'(2'b10));
    check_all("R7 O diag");

    // R8 draw: X O X / X O O / O X X
    cyc(0,0,0,0,0,1);
    put(0,0); put(0,1); put(0,2); put(1,1); put(1,0);
    put(1,2); put(2,1); put(2,0); put(2,2);
    check("R8 draw code", 32'(res), 32'(2'b11));
    check_all("R8 draw");

    // random play
    for (int g = 0; g < 300; g++) begin
      bit u, d, l, r, p;
      int k;
      k = $urandom_range(0, 9);
      u = (k == 0); d = (k == 1); l = (k == 2); r = (k == 3);
      p = (k >= 6) || ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) begin u = 1; r = 1; end
      cyc(u, d, l, r, p, (m_res != 0) && ($urandom_range(0, 3) == 0));
      check_all("R5 random");
      if (watchdog_hit) break;
    end

    if (watchdog_hit) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule